// File: doc/BRIEF.md
# Beam-Position Wait and Skip Condition Unit

This unit decides when a display-list coprocessor may leave a WAIT instruction, and whether a SKIP instruction discards the instruction after it. It compares the current video beam position with a target position held in the instruction's first word. The comparison is masked bit by bit by enable fields in the second word. A flag in the second word can also require the blitter to be idle before the condition counts as met.

The blitter idle status is sampled when the second instruction word is fetched. It is not sampled when the comparison is made. A WAIT that captured "busy" at fetch time looks at the blitter again when its beam target is reached. If the blitter has finished by then, the unit evaluates once more on the next cycle and does not stall. If the blitter is still running, the unit stalls in a blitter-wait state until the busy status drops.

A SKIP never stalls. It loads a one-bit ignore-next flag from the qualified condition, and the instruction sequencer clears that flag once it has consumed the next instruction.

Top module: `beam_cond_unit`

## Requirements
- R1: The vertical target is word1[15:8] ANDed with the mask {1, word2[14:8]}, and the beam vertical position is ANDed with the same mask. The top vertical bit is therefore always compared.
- R2: The horizontal target is word1[7:1] masked by word2[7:1]. The beam horizontal position is masked by the same word2[7:1]. Bit 0 of both the target and the position takes no part in the comparison.
- R3: The position condition holds when the masked vertical position is greater than the vertical target. It also holds when the two are equal and the masked horizontal position is greater than or equal to the horizontal target.
- R4: An odd beam horizontal position is compared as if it were 0.
- R5: When word2[15] is 0, the condition also requires the sampled blitter status to be idle. When word2[15] is 1, blitter status has no effect.
- R6: Blitter busy is captured in the cycle in which fetch_w2 is high. A change of blit_busy after that capture does not alter a SKIP result.
- R7: A WAIT behaves as follows when it captured busy, its position condition is met, and blit_busy is already low. With RECHECK_EN=1 it stays in the polling state without raising blt_stall, and it asserts wait_done one cycle later.
- R8: A WAIT raises blt_stall when it captured busy, its position condition is met, and blit_busy is still high. It stays stalled while blit_busy is high. wait_done is asserted in the cycle after blit_busy goes low.
- R9: cmd_skip loads skip_next with the qualified condition in the next cycle, without making wait_active high. ins_taken clears skip_next.
- R10: An unsatisfied WAIT is re-evaluated every cycle with wait_active high. Once it is satisfied, wait_done is high for exactly one cycle and wait_active falls at the same edge.
- R11: Reset clears skip_next, wait_done, wait_active and blt_stall, and drops any WAIT in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_w1 | input | 16 | First instruction word: vertical target in [15:8], horizontal target in [7:1] |
| ins_w2 | input | 16 | Second instruction word: blitter-ignore in [15], vertical enables in [14:8], horizontal enables in [7:1] |
| beam_v | input | VPOS_W | Beam vertical counter; the low 8 bits are compared |
| beam_h | input | HPOS_W | Beam horizontal counter; the low 8 bits are compared |
| blit_busy | input | 1 | Blitter busy status |
| fetch_w2 | input | 1 | Second word is being fetched this cycle; blitter status is captured |
| cmd_wait | input | 1 | Start a WAIT |
| cmd_skip | input | 1 | Evaluate a SKIP |
| ins_taken | input | 1 | The instruction after a SKIP has been consumed; clears skip_next |
| wait_done | output | 1 | One-cycle pulse when a WAIT is satisfied |
| wait_active | output | 1 | A WAIT is in progress |
| blt_stall | output | 1 | The WAIT is held waiting for the blitter |
| skip_next | output | 1 | Discard the next instruction |

## Verification
The hardest case to reach is the recheck window. The unit must capture blitter busy at fetch time and then find the blitter already idle at the moment the beam target is met. The bench raises blit_busy only during the fetch_w2 cycle, lowers it before the WAIT starts, and places the beam already past the target. The result is therefore decided solely by the stale capture. The bench also inverts blit_busy between fetch and SKIP throughout a long pseudo-random sweep of word pairs and beam positions. This shows that only the captured value counts.

// File: rtl/beam_cmp_pkg.sv
package beam_cmp_pkg;
   localparam int WORD_W = 16;
   localparam int CMP_W  = 8;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_POLL = 2'd1,
      WS_BLIT = 2'd2
   } wstate_t;
endpackage

// File: rtl/beam_pos_cmp.sv
module beam_pos_cmp
   import beam_cmp_pkg::*;
(
   input  logic [WORD_W-1:0] w1,
   input  logic [WORD_W-1:0] w2,
   input  logic [CMP_W-1:0]  vpos,
   input  logic [CMP_W-1:0]  hpos,
   output logic              pos_hit
);
   logic [CMP_W-1:0] v_mask, h_mask;
   logic [CMP_W-1:0] v_tgt, h_tgt, v_cur, h_cur, h_even;
   logic             unused_w2_lsb;

   assign unused_w2_lsb = w2[0];

   always_comb begin
      v_mask  = {1'b1, w2[14:8]};
      h_mask  = {w2[7:1], 1'b0};
      h_even  = hpos[0] ? '0 : hpos;
      v_tgt   = w1[15:8] & v_mask;
      h_tgt   = w1[7:0] & h_mask;
      v_cur   = vpos & v_mask;
      h_cur   = h_even & h_mask;
      pos_hit = (v_cur > v_tgt) || ((v_cur == v_tgt) && (h_cur >= h_tgt));
   end
endmodule

// File: rtl/busy_snap.sv
module busy_snap (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch,
   input  logic ign_blt,
   input  logic blit_busy,
   input  logic clr,
   output logic busy_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     busy_q <= 1'b0;
      else if (fetch) busy_q <= blit_busy & ~ign_blt;
      else if (clr)   busy_q <= 1'b0;
   end
endmodule

// File: rtl/wait_seq.sv
module wait_seq
   import beam_cmp_pkg::*;
#(
   parameter bit RECHECK_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic pos_hit,
   input  logic ign_blt,
   input  logic busy_q,
   input  logic blit_busy,
   output logic done,
   output logic active,
   output logic stall,
   output logic recheck_clr
);
   wstate_t st, st_nx;
   logic    done_nx, stale_busy;

   assign stale_busy = (st == WS_POLL) && pos_hit && !ign_blt && busy_q && !blit_busy;

   generate
      if (RECHECK_EN) begin : g_recheck
         assign recheck_clr = stale_busy;
      end else begin : g_direct
         assign recheck_clr = 1'b0;
      end
   endgenerate

   always_comb begin
      st_nx   = st;
      done_nx = 1'b0;
      unique case (st)
         WS_IDLE: if (start) st_nx = WS_POLL;
         WS_POLL: begin
            if (pos_hit && (ign_blt || !busy_q)) begin
               done_nx = 1'b1;
               st_nx   = WS_IDLE;
            end else if (pos_hit && !recheck_clr) begin
               st_nx = WS_BLIT;
            end
         end
         WS_BLIT: if (!blit_busy) begin
            done_nx = 1'b1;
            st_nx   = WS_IDLE;
         end
         default: st_nx = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= WS_IDLE;
         done <= 1'b0;
      end else begin
         st   <= st_nx;
         done <= done_nx;
      end
   end

   assign active = (st != WS_IDLE);
   assign stall  = (st == WS_BLIT);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> $past(blit_busy));
   // R8
   stall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !blit_busy) |=> (done && !stall));
   // R7
   recheck_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (RECHECK_EN && stale_busy) |=> (!stall && active));
endmodule

// File: rtl/beam_cond_unit.sv
module beam_cond_unit
   import beam_cmp_pkg::*;
#(
   parameter int VPOS_W     = 8,
   parameter int HPOS_W     = 8,
   parameter bit RECHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       ins_w1,
   input  logic [15:0]       ins_w2,
   input  logic [VPOS_W-1:0] beam_v,
   input  logic [HPOS_W-1:0] beam_h,
   input  logic              blit_busy,
   input  logic              fetch_w2,
   input  logic              cmd_wait,
   input  logic              cmd_skip,
   input  logic              ins_taken,
   output logic              wait_done,
   output logic              wait_active,
   output logic              blt_stall,
   output logic              skip_next
);
   generate
      if (VPOS_W < CMP_W) begin : g_bad_v
         $error("VPOS_W must be at least 8");
      end
      if (HPOS_W < CMP_W) begin : g_bad_h
         $error("HPOS_W must be at least 8");
      end
   endgenerate

   logic pos_hit, busy_q, recheck_clr, qual_hit, ign_blt;

   assign ign_blt = ins_w2[15];

   beam_pos_cmp u_cmp (
      .w1      (ins_w1),
      .w2      (ins_w2),
      .vpos    (beam_v[CMP_W-1:0]),
      .hpos    (beam_h[CMP_W-1:0]),
      .pos_hit (pos_hit)
   );

   busy_snap u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch     (fetch_w2),
      .ign_blt   (ign_blt),
      .blit_busy (blit_busy),
      .clr       (recheck_clr),
      .busy_q    (busy_q)
   );

   wait_seq #(.RECHECK_EN(RECHECK_EN)) u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (cmd_wait),
      .pos_hit     (pos_hit),
      .ign_blt     (ign_blt),
      .busy_q      (busy_q),
      .blit_busy   (blit_busy),
      .done        (wait_done),
      .active      (wait_active),
      .stall       (blt_stall),
      .recheck_clr (recheck_clr)
   );

   assign qual_hit = pos_hit && (ign_blt || !busy_q);

   always_ff @(posedge clk) begin
      if (!rst_n)         skip_next <= 1'b0;
      else if (cmd_skip)  skip_next <= qual_hit;
      else if (ins_taken) skip_next <= 1'b0;
   end

   // R9
   skip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_skip |=> (skip_next == $past(qual_hit)));
   // R9
   skip_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_skip && !wait_active && !cmd_wait) |=> !wait_active);
   // R9
   skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_taken && !cmd_skip) |=> !skip_next);
endmodule

// File: tb/sim_beam_cond_unit.sv
module sim_beam_cond_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ins_w1 = '0, ins_w2 = '0;
   logic [7:0]  beam_v = '0, beam_h = '0;
   logic        blit_busy = 1'b0, fetch_w2 = 1'b0;
   logic        cmd_wait = 1'b0, cmd_skip = 1'b0, ins_taken = 1'b0;
   logic        wait_done, wait_active, blt_stall, skip_next;
   int          n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   beam_cond_unit #(.VPOS_W(8), .HPOS_W(8), .RECHECK_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ins_w1(ins_w1), .ins_w2(ins_w2),
      .beam_v(beam_v), .beam_h(beam_h), .blit_busy(blit_busy),
      .fetch_w2(fetch_w2), .cmd_wait(cmd_wait), .cmd_skip(cmd_skip),
      .ins_taken(ins_taken), .wait_done(wait_done), .wait_active(wait_active),
      .blt_stall(blt_stall), .skip_next(skip_next));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic model(input logic [15:0] a, input logic [15:0] b,
                                  input logic [7:0] v, input logic [7:0] h,
                                  input logic busy);
      logic [7:0] vm, hm, hh;
      logic       hit;
      vm  = {1'b1, b[14:8]};
      hm  = {b[7:1], 1'b0};
      hh  = (h % 2 == 1) ? 8'd0 : h;
      hit = ((v & vm) > (a[15:8] & vm)) ||
            (((v & vm) == (a[15:8] & vm)) && ((hh & hm) >= (a[7:0] & hm)));
      return hit && (b[15] || !busy);
   endfunction

   task automatic fetch(input logic [15:0] a, input logic [15:0] b, input logic busy);
      @(negedge clk);
      ins_w1 = a; ins_w2 = b; blit_busy = busy; fetch_w2 = 1'b1;
      @(negedge clk);
      fetch_w2 = 1'b0;
   endtask

   task automatic skip_case(input logic [15:0] a, input logic [15:0] b,
                            input logic [7:0] v, input logic [7:0] h,
                            input logic busy, input string req);
      fetch(a, b, busy);
      blit_busy = ~busy;
      beam_v = v; beam_h = h; cmd_skip = 1'b1;
      @(negedge clk);
      cmd_skip = 1'b0;
      chk(req, skip_next, model(a, b, v, h, busy));
      chk("R9 skip no stall", wait_active, 1'b0);
      ins_taken = 1'b1;
      @(negedge clk);
      ins_taken = 1'b0;
      chk("R9 cleared by ins_taken", skip_next, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      lf = 32'h1D872B41;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset skip_next", skip_next, 1'b0);
      chk("R11 reset wait_done", wait_done, 1'b0);
      chk("R11 reset wait_active", wait_active, 1'b0);
      chk("R11 reset blt_stall", blt_stall, 1'b0);
      rst_n = 1'b1;

      // R4 odd horizontal positions compare as zero
      skip_case(16'h3010, 16'hFFFE, 8'h30, 8'h11, 1'b0, "R4 odd h as zero");
      skip_case(16'h3010, 16'hFFFE, 8'h30, 8'h12, 1'b0, "R4 even h above");
      skip_case(16'h3010, 16'hFFFE, 8'h30, 8'h10, 1'b0, "R3 equal h");
      // R2 target bit0 ignored
      skip_case(16'h3011, 16'hFFFF, 8'h30, 8'h10, 1'b0, "R2 bit0 ignored");
      // R1 vertical MSB always compared
      skip_case(16'h80FE, 16'h8000, 8'h7F, 8'h00, 1'b0, "R1 msb forced low");
      skip_case(16'h80FE, 16'h8000, 8'h81, 8'h00, 1'b0, "R1 msb forced high");
      // R5 / R6 blitter qualifier
      skip_case(16'h0000, 16'h7F00, 8'h10, 8'h10, 1'b1, "R5 busy blocks");
      skip_case(16'h0000, 16'hFF00, 8'h10, 8'h10, 1'b1, "R5 busy ignored");
      skip_case(16'h0000, 16'h7F00, 8'h10, 8'h10, 1'b0, "R6 late busy ignored");

      // sweep
      for (int n = 0; n < 2048; n++) begin
         logic [15:0] a, b;
         logic [7:0]  v, h;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a  = lf[15:0];
         b  = lf[28] ? 16'hFFFE : {lf[31:24] ^ lf[7:0], lf[23:16]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         v  = lf[4] ? a[15:8] : lf[15:8];
         h  = lf[5] ? (a[7:0] + {6'd0, lf[1:0]} - 8'd2) : lf[23:16];
         skip_case(a, b, v, h, lf[9], "R1/R2/R3/R4/R5/R6 sweep");
      end

      // R10 wait polls until satisfied, one-cycle done
      fetch(16'h2040, 16'hFFFE, 1'b0);
      beam_v = 8'h20; beam_h = 8'h10; cmd_wait = 1'b1;
      @(negedge clk);
      cmd_wait = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R10 unsatisfied no done", wait_done, 1'b0);
         chk("R10 still active", wait_active, 1'b1);
      end
      beam_h = 8'h40;
      @(negedge clk);
      chk("R10 done pulse", wait_done, 1'b1);
      chk("R10 inactive after done", wait_active, 1'b0);
      @(negedge clk);
      chk("R10 done single cycle", wait_done, 1'b0);

      // R7 stale busy recheck
      fetch(16'h1000, 16'h7F00, 1'b1);
      blit_busy = 1'b0; beam_v = 8'h20; beam_h = 8'h00; cmd_wait = 1'b1;
      @(negedge clk);
      cmd_wait = 1'b0;
      @(negedge clk);
      chk("R7 no stall on recheck", blt_stall, 1'b0);
      chk("R7 no done yet", wait_done, 1'b0);
      @(negedge clk);
      chk("R7 done after recheck", wait_done, 1'b1);

      // R8 blitter stall
      fetch(16'h1000, 16'h7F00, 1'b1);
      beam_v = 8'h20; cmd_wait = 1'b1;
      @(negedge clk);
      cmd_wait = 1'b0;
      @(negedge clk);
      chk("R8 stall entered", blt_stall, 1'b1);
      repeat (3) @(negedge clk);
      chk("R8 held while busy", blt_stall, 1'b1);
      chk("R8 no done while busy", wait_done, 1'b0);
      blit_busy = 1'b0;
      @(negedge clk);
      chk("R8 done after busy drop", wait_done, 1'b1);
      chk("R8 stall released", blt_stall, 1'b0);

      // R11 reset mid-wait and with flag set
      fetch(16'hFF00, 16'hFFFE, 1'b0);
      beam_v = 8'h00; cmd_wait = 1'b1;
      @(negedge clk);
      cmd_wait = 1'b0;
      ins_w1 = 16'h0000; cmd_skip = 1'b1;
      @(negedge clk);
      cmd_skip = 1'b0;
      chk("R9 skip set", skip_next, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R11 reset clears skip", skip_next, 1'b0);
      chk("R11 reset drops wait", wait_active, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule